// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Controller

This block routes a set of interrupt input lines to processors. Each line has its own 64-bit redirection entry. The entry holds a mask, a trigger mode, a polarity, a vector, a delivery mode, a destination mode and a destination. Software never addresses an entry directly. It writes an 8-bit index into a select register, then reads or writes a 32-bit data window that reaches whichever register the index names. Each entry is split over two consecutive indices. A small identifier register and a read-only version register share the same index space.

When an entry has a request, the block raises a delivery request. The request carries the vector, destination and modes, and it stays up until a processor-side acknowledge. Edge-triggered lines deliver once for each active edge. Level-triggered lines deliver once and then set a remote-IRR flag. That flag blocks further deliveries until software writes the vector to a direct end-of-interrupt register, which clears the flag in every level-triggered entry with that vector.

Top module: `irq_redirect`

## Requirements
- R1: A bus write to byte offset 0x00 stores bits 7:0 as the register index, and a read of offset 0x00 returns it zero-extended. Reads and writes at offset 0x10 reach the register that the stored index selects.
- R2: Entry n sits at index 0x10+2n (low word) and 0x11+2n (high word). In the low word, bits 7:0 are the vector, 10:8 the delivery mode, 11 the destination mode, 13 the polarity (1 = active low), 15 the trigger mode (1 = level) and 16 the mask. Bits 31:24 of the high word are the destination. All other bits read as zero.
- R3: Index 0x01 is read-only. It returns the version 0x20 in bits 7:0 and the number of entries minus one in bits 23:16.
- R4: Index 0x00 holds a writable 4-bit identifier in bits 27:24, and its other bits read as zero.
- R5: Low-word bit 12 (delivery status) and bit 14 (remote IRR) are read-only, and writes to them have no effect.
- R6: After reset, every entry reads 0x00010000 (low) and 0 (high). The index and identifier read 0, and no delivery is requested.
- R7: An unmasked edge-triggered entry latches a request on the active edge of its line: rising when polarity is 0, falling when polarity is 1. Bit 12 reads 1 while the request is held. The request is delivered once, and an edge that arrives while the entry is masked is lost.
- R8: An unmasked level-triggered entry whose line is active and whose remote IRR is clear is delivered once. The acknowledge sets remote IRR (bit 14), and no further delivery follows while it stays set.
- R9: A write to offset 0x40 clears remote IRR in every level-triggered entry whose vector equals bits 7:0 of the write. Other entries are unaffected. If the line is still active, a new delivery follows.
- R10: When several entries request at once, the lowest-numbered entry is delivered first.
- R11: While the delivery request is up and unacknowledged, the request and its vector, destination and mode outputs hold. The request drops on the cycle after the acknowledge.
- R12: Indices past the last entry and unassigned indices read zero and ignore writes. Reads at any offset other than 0x00 and 0x10 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Bus access this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 7 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational on the address |
| irqIn | input | NUM_ENTRIES | Interrupt input lines, one per entry |
| dlvValid | output | 1 | Delivery request |
| dlvVector | output | 8 | Vector of the delivered entry |
| dlvDest | output | 8 | Destination of the delivered entry |
| dlvDelMode | output | 3 | Delivery mode of the delivered entry |
| dlvDestMode | output | 1 | Destination mode of the delivered entry |
| dlvLevel | output | 1 | 1 if the delivered entry is level-triggered |
| dlvAck | input | 1 | Acknowledge of the delivery request |

## Verification
Delivery is exercised with four kinds of line pattern:
- A rising edge on an active-high entry, held high afterwards. This separates a single delivery from repeated ones.
- A pulse on an active-low entry. This tells polarity handling apart from plain edge detection.
- An edge that arrives while the entry is masked, followed by unmasking. This shows whether the dropped edge stays dropped.
- A held level line, run through an acknowledge, an end-of-interrupt with a wrong vector and one with the right vector, then released before a last end-of-interrupt.

Two lines raised together check the order of service. A table of index and data pairs separates writable fields from read-only, reserved and unimplemented bits.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  localparam int ENT_SEL_W = 7;
  localparam int ENT_BASE_IDX = 16;

  localparam logic [6:0] OFF_SEL = 7'h00;
  localparam logic [6:0] OFF_WIN = 7'h10;
  localparam logic [6:0] OFF_EOI = 7'h40;

  localparam logic [7:0] IDX_ID  = 8'h00;
  localparam logic [7:0] IDX_VER = 8'h01;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_ID,
    REG_VER,
    REG_LO,
    REG_HI
  } regKind_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic                 loWr;
    logic                 hiWr;
    logic                 eoiWr;
    logic [ENT_SEL_W-1:0] entSel;
  } ctrlStrobes_t;

  typedef struct packed {
    logic [7:0] vector;
    logic [2:0] delMode;
    logic       destMode;
    logic       pol;
    logic       trig;
    logic       mask;
    logic [7:0] dest;
  } entCfg_t;

  localparam entCfg_t RESET_CFG = '{vector: 8'h00, delMode: 3'd0, destMode: 1'b0,
                                    pol: 1'b0, trig: 1'b0, mask: 1'b1, dest: 8'h00};

endpackage

// File: rtl/irq_redir_ctrl.sv
module irq_redir_ctrl
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENTRIES = 8,
  parameter logic [7:0] VERSION     = 8'h20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         busValid,
  input  logic         busWrite,
  input  logic [6:0]   busAddr,
  input  logic [31:0]  busWdata,
  input  logic [31:0]  entLoWord,
  input  logic [31:0]  entHiWord,
  output ctrlStrobes_t strb,
  output logic [31:0]  busRdata
);

  localparam int LAST_IDX = ENT_BASE_IDX + 2 * NUM_ENTRIES - 1;
  localparam logic [7:0] LAST_ENTRY = 8'(NUM_ENTRIES - 1);

  logic [7:0] selIdx;
  logic [3:0] idReg;
  logic       wrSel, wrWin, wrEoi, rdSel, rdWin, selIsEnt;
  logic [7:0] entOff;
  regKind_t   kind;
  logic       unusedWdata;

  assign wrSel = busValid & busWrite & (busAddr == OFF_SEL);
  assign wrWin = busValid & busWrite & (busAddr == OFF_WIN);
  assign wrEoi = busValid & busWrite & (busAddr == OFF_EOI);
  assign rdSel = busValid & ~busWrite & (busAddr == OFF_SEL);
  assign rdWin = busValid & ~busWrite & (busAddr == OFF_WIN);

  assign selIsEnt = (int'(selIdx) >= ENT_BASE_IDX) && (int'(selIdx) <= LAST_IDX);
  assign entOff   = selIdx - 8'(ENT_BASE_IDX);

  always_comb begin
    if (selIdx == IDX_ID)       kind = REG_ID;
    else if (selIdx == IDX_VER) kind = REG_VER;
    else if (selIsEnt)          kind = selIdx[0] ? REG_HI : REG_LO;
    else                        kind = REG_NONE;
  end

  assign strb.loWr   = wrWin & (kind == REG_LO);
  assign strb.hiWr   = wrWin & (kind == REG_HI);
  assign strb.eoiWr  = wrEoi;
  assign strb.entSel = entOff[7:1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selIdx <= 8'h00;
      idReg  <= 4'h0;
    end else begin
      if (wrSel) selIdx <= busWdata[7:0];
      if (wrWin && kind == REG_ID) idReg <= busWdata[27:24];
    end
  end

  always_comb begin
    busRdata = 32'h0;
    if (rdSel) begin
      busRdata = {24'h0, selIdx};
    end else if (rdWin) begin
      case (kind)
        REG_ID:  busRdata = {4'h0, idReg, 24'h0};
        REG_VER: busRdata = {8'h00, LAST_ENTRY, 8'h00, VERSION};
        REG_LO:  busRdata = entLoWord;
        REG_HI:  busRdata = entHiWord;
        default: busRdata = 32'h0;
      endcase
    end
  end

  assign unusedWdata = ^{busWdata[31:28], busWdata[23:8]};

endmodule

// File: rtl/irq_redir_datapath.sv
module irq_redir_datapath
  import irq_redir_pkg::*;
#(
  parameter int NUM_ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStrobes_t           strb,
  input  logic [31:0]            busWdata,
  input  logic [NUM_ENTRIES-1:0] irqIn,
  input  logic                   dlvAck,
  output logic [31:0]            entLoWord,
  output logic [31:0]            entHiWord,
  output logic                   dlvValid,
  output logic [7:0]             dlvVector,
  output logic [7:0]             dlvDest,
  output logic [2:0]             dlvDelMode,
  output logic                   dlvDestMode,
  output logic                   dlvLevel
);

  localparam int SEL_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  entCfg_t                cfg [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] prevRaw, pendEdge, rirr;
  logic [NUM_ENTRIES-1:0] req, edgeHit, eoiHit, ackHit;
  logic [SEL_W-1:0]       dlvIdx, winIdx;
  logic                   anyReq;
  entCfg_t                rdCfg;
  logic                   rdStat, rdIrr;
  logic                   unusedWdata;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    logic actNow, actPrev;
    assign actNow     = irqIn[i] ^ cfg[i].pol;
    assign actPrev    = prevRaw[i] ^ cfg[i].pol;
    assign edgeHit[i] = actNow & ~actPrev;
    assign eoiHit[i]  = strb.eoiWr & cfg[i].trig & (cfg[i].vector == busWdata[7:0]);
    assign ackHit[i]  = dlvValid & dlvAck & (dlvIdx == SEL_W'(i));
    assign req[i]     = ~cfg[i].mask & (cfg[i].trig ? (actNow & ~rirr[i]) : pendEdge[i]);
  end

  // lowest-numbered requester wins
  always_comb begin
    winIdx = '0;
    anyReq = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (req[i]) begin
        winIdx = SEL_W'(i);
        anyReq = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_ENTRIES; i++) cfg[i] <= RESET_CFG;
      prevRaw  <= '0;
      pendEdge <= '0;
      rirr     <= '0;
    end else begin
      prevRaw <= irqIn;
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (strb.loWr && strb.entSel == ENT_SEL_W'(i)) begin
          cfg[i].vector   <= busWdata[7:0];
          cfg[i].delMode  <= busWdata[10:8];
          cfg[i].destMode <= busWdata[11];
          cfg[i].pol      <= busWdata[13];
          cfg[i].trig     <= busWdata[15];
          cfg[i].mask     <= busWdata[16];
        end
        if (strb.hiWr && strb.entSel == ENT_SEL_W'(i)) cfg[i].dest <= busWdata[31:24];

        if (cfg[i].trig)                          pendEdge[i] <= 1'b0;
        else if (edgeHit[i] && !cfg[i].mask)      pendEdge[i] <= 1'b1;
        else if (ackHit[i])                       pendEdge[i] <= 1'b0;

        if (cfg[i].trig && ackHit[i]) rirr[i] <= 1'b1;
        else if (eoiHit[i])           rirr[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dlvValid    <= 1'b0;
      dlvIdx      <= '0;
      dlvVector   <= 8'h00;
      dlvDest     <= 8'h00;
      dlvDelMode  <= 3'd0;
      dlvDestMode <= 1'b0;
      dlvLevel    <= 1'b0;
    end else if (dlvValid) begin
      if (dlvAck) dlvValid <= 1'b0;
    end else if (anyReq) begin
      dlvValid    <= 1'b1;
      dlvIdx      <= winIdx;
      dlvVector   <= cfg[winIdx].vector;
      dlvDest     <= cfg[winIdx].dest;
      dlvDelMode  <= cfg[winIdx].delMode;
      dlvDestMode <= cfg[winIdx].destMode;
      dlvLevel    <= cfg[winIdx].trig;
    end
  end

  always_comb begin
    rdCfg  = RESET_CFG;
    rdStat = 1'b0;
    rdIrr  = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (strb.entSel == ENT_SEL_W'(i)) begin
        rdCfg  = cfg[i];
        rdStat = req[i];
        rdIrr  = rirr[i];
      end
    end
  end

  assign entLoWord = {15'h0, rdCfg.mask, rdCfg.trig, rdIrr, rdCfg.pol, rdStat,
                      rdCfg.destMode, rdCfg.delMode, rdCfg.vector};
  assign entHiWord = {rdCfg.dest, 24'h0};

  assign unusedWdata = ^{busWdata[23:17], busWdata[14], busWdata[12]};

endmodule

// File: rtl/irq_redirect.sv
module irq_redirect
  import irq_redir_pkg::*;
#(
  parameter int         NUM_ENTRIES = 8,
  parameter logic [7:0] VERSION     = 8'h20
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [6:0]             busAddr,
  input  logic [31:0]            busWdata,
  output logic [31:0]            busRdata,
  input  logic [NUM_ENTRIES-1:0] irqIn,
  output logic                   dlvValid,
  output logic [7:0]             dlvVector,
  output logic [7:0]             dlvDest,
  output logic [2:0]             dlvDelMode,
  output logic                   dlvDestMode,
  output logic                   dlvLevel,
  input  logic                   dlvAck
);

  ctrlStrobes_t strb;
  logic [31:0]  entLoWord, entHiWord;

  irq_redir_ctrl #(.NUM_ENTRIES(NUM_ENTRIES), .VERSION(VERSION)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .entLoWord(entLoWord),
    .entHiWord(entHiWord), .strb(strb), .busRdata(busRdata)
  );

  irq_redir_datapath #(.NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .irqIn(irqIn),
    .dlvAck(dlvAck), .entLoWord(entLoWord), .entHiWord(entHiWord),
    .dlvValid(dlvValid), .dlvVector(dlvVector), .dlvDest(dlvDest),
    .dlvDelMode(dlvDelMode), .dlvDestMode(dlvDestMode), .dlvLevel(dlvLevel)
  );

endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic        busWrite,
  input logic [6:0]  busAddr,
  input logic [31:0] busRdata,
  input logic        dlvValid,
  input logic [7:0]  dlvVector,
  input logic [7:0]  dlvDest,
  input logic [2:0]  dlvDelMode,
  input logic        dlvLevel,
  input logic        dlvAck
);

  // R11
  dlv_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && !dlvAck |=> dlvValid);

  // R11
  dlv_payload_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && !dlvAck |=> $stable(dlvVector) && $stable(dlvDest)
                            && $stable(dlvDelMode) && $stable(dlvLevel));

  // R11
  dlv_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    dlvValid && dlvAck |=> !dlvValid);

  // R12
  unassigned_offset_chk: assert property (@(posedge clk) disable iff (!rstN)
    busValid && !busWrite && busAddr != 7'h00 && busAddr != 7'h10 |-> busRdata == 32'h0);

endmodule

bind irq_redirect irq_redir_chk u_chk (.*);

// File: tb/tb_irq_redirect.sv
`timescale 1ns/1ps
module tb_irq_redirect;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         busValid = 1'b0;
  logic         busWrite = 1'b0;
  logic [6:0]   busAddr = 7'h0;
  logic [31:0]  busWdata = 32'h0;
  logic [31:0]  busRdata;
  logic [N-1:0] irqIn = '0;
  logic         dlvValid;
  logic [7:0]   dlvVector, dlvDest;
  logic [2:0]   dlvDelMode;
  logic         dlvDestMode, dlvLevel;
  logic         dlvAck = 1'b0;

  int  nRun = 0;
  int  nFail = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  irq_redirect #(.NUM_ENTRIES(N)) dut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata), .irqIn(irqIn),
    .dlvValid(dlvValid), .dlvVector(dlvVector), .dlvDest(dlvDest),
    .dlvDelMode(dlvDelMode), .dlvDestMode(dlvDestMode), .dlvLevel(dlvLevel),
    .dlvAck(dlvAck)
  );

  // index, write data, expected read-back
  localparam int NV = 9;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'hFFFF_FFFF, 32'h0F00_0000},
    {8'h01, 32'hFFFF_FFFF, 32'h0007_0020},
    {8'h1E, 32'h0001_5077, 32'h0001_0077},
    {8'h1F, 32'hFFFF_FFFF, 32'hFF00_0000},
    {8'h1C, 32'hFFFF_FFFF, 32'h0001_AFFF},
    {8'h1C, 32'h0001_0000, 32'h0001_0000},
    {8'h20, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h05, 32'h1234_5678, 32'h0000_0000},
    {8'hFF, 32'hFFFF_FFFF, 32'h0000_0000}
  };
  localparam string VREQ [NV] = '{"R4", "R3", "R5", "R2", "R2", "R2", "R12", "R12", "R12"};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [6:0] addr, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [6:0] addr, output logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = addr;
    #1 data = busRdata;
    busValid = 1'b0;
  endtask

  task automatic idxWr(input logic [7:0] idx, input logic [31:0] data);
    busWr(7'h00, {24'h0, idx});
    busWr(7'h10, data);
  endtask

  task automatic idxRd(input logic [7:0] idx, output logic [31:0] data);
    busWr(7'h00, {24'h0, idx});
    busRd(7'h10, data);
  endtask

  task automatic waitDlv(output bit got);
    got = 1'b0;
    for (int c = 0; c < 10 && !got; c++) begin
      @(negedge clk);
      #1 if (dlvValid) got = 1'b1;
    end
  endtask

  task automatic ackDlv();
    @(negedge clk);
    dlvAck = 1'b1;
    @(negedge clk);
    dlvAck = 1'b0;
    #1;
  endtask

  task automatic quiet(input int n, output bit seen);
    seen = 1'b0;
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      #1 if (dlvValid) seen = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit got, seen;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R6 reset state
    #1 check("R6 no delivery after reset", {31'h0, dlvValid}, 32'h0);
    busRd(7'h00, rd);
    check("R6 select resets to 0", rd, 32'h0);
    busRd(7'h10, rd);
    check("R6 identifier resets to 0", rd, 32'h0);
    for (int e = 0; e < N; e++) begin
      idxRd(8'(16 + 2 * e), rd);
      check("R6 entry low word", rd, 32'h0001_0000);
      idxRd(8'(17 + 2 * e), rd);
      check("R6 entry high word", rd, 32'h0);
    end

    // register table
    for (int v = 0; v < NV; v++) begin
      idxWr(VEC[v][71:64], VEC[v][63:32]);
      busRd(7'h00, rd);
      check("R1 select read-back", rd, {24'h0, VEC[v][71:64]});
      busRd(7'h10, rd);
      check(VREQ[v], rd, VEC[v][31:0]);
    end

    // R12 other offsets read zero
    busRd(7'h08, rd);
    check("R12 offset 0x08 reads zero", rd, 32'h0);
    busRd(7'h40, rd);
    check("R12 offset 0x40 reads zero", rd, 32'h0);

    // R7 rising edge, entry 2
    idxWr(8'h15, 32'h0500_0000);
    idxWr(8'h14, 32'h0000_0031);
    @(negedge clk); irqIn[2] = 1'b1;
    waitDlv(got);
    check("R7 edge delivered", {31'h0, got}, 32'h1);
    check("R7 edge vector", {24'h0, dlvVector}, 32'h31);
    check("R7 edge destination", {24'h0, dlvDest}, 32'h05);
    check("R7 edge trigger flag", {31'h0, dlvLevel}, 32'h0);
    idxRd(8'h14, rd);
    check("R7 delivery status set while pending", rd, 32'h0000_1031);
    check("R11 request held without ack", {31'h0, dlvValid}, 32'h1);
    ackDlv();
    check("R11 request drops after ack", {31'h0, dlvValid}, 32'h0);
    quiet(6, seen);
    check("R7 edge delivered once", {31'h0, seen}, 32'h0);
    idxRd(8'h14, rd);
    check("R7 delivery status clear after ack", rd, 32'h0000_0031);

    // R7 edge while masked is dropped, entry 3
    idxWr(8'h16, 32'h0001_0040);
    @(negedge clk); irqIn[3] = 1'b1;
    repeat (3) @(negedge clk);
    idxWr(8'h16, 32'h0000_0040);
    quiet(6, seen);
    check("R7 masked edge dropped", {31'h0, seen}, 32'h0);

    // R7 active-low edge, entry 4
    idxWr(8'h18, 32'h0000_2045);
    quiet(3, seen);
    check("R7 no delivery on polarity change", {31'h0, seen}, 32'h0);
    @(negedge clk); irqIn[4] = 1'b1;
    quiet(3, seen);
    check("R7 rising edge ignored when active low", {31'h0, seen}, 32'h0);
    @(negedge clk); irqIn[4] = 1'b0;
    waitDlv(got);
    check("R7 falling edge delivered", {31'h0, got}, 32'h1);
    check("R7 active-low vector", {24'h0, dlvVector}, 32'h45);
    ackDlv();

    // R8 / R9 level entry 5
    idxWr(8'h1B, 32'h0900_0000);
    idxWr(8'h1A, 32'h0000_8952);
    @(negedge clk); irqIn[5] = 1'b1;
    waitDlv(got);
    check("R8 level delivered", {31'h0, got}, 32'h1);
    check("R8 level vector", {24'h0, dlvVector}, 32'h52);
    check("R8 level modes", {24'h0, dlvDest, 1'b0, dlvDelMode, dlvDestMode, dlvLevel},
          {24'h0, 8'h09, 1'b0, 3'd1, 1'b1, 1'b1});
    ackDlv();
    idxRd(8'h1A, rd);
    check("R8 remote IRR set after ack", rd, 32'h0000_C952);
    quiet(6, seen);
    check("R8 no redelivery while remote IRR set", {31'h0, seen}, 32'h0);
    busWr(7'h40, 32'h0000_0053);
    quiet(4, seen);
    check("R9 mismatching EOI has no effect", {31'h0, seen}, 32'h0);
    busWr(7'h40, 32'h0000_0031);
    quiet(4, seen);
    check("R9 EOI for edge vector has no effect", {31'h0, seen}, 32'h0);
    busWr(7'h40, 32'h0000_0052);
    waitDlv(got);
    check("R9 matching EOI redelivers held line", {31'h0, got}, 32'h1);
    ackDlv();
    @(negedge clk); irqIn[5] = 1'b0;
    busWr(7'h40, 32'h0000_0052);
    quiet(5, seen);
    check("R9 released line not redelivered", {31'h0, seen}, 32'h0);
    idxRd(8'h1A, rd);
    check("R9 remote IRR cleared by EOI", rd, 32'h0000_8952);

    // R10 priority, entries 0 and 1
    idxWr(8'h10, 32'h0000_0060);
    idxWr(8'h12, 32'h0000_0061);
    @(negedge clk); irqIn[1:0] = 2'b11;
    waitDlv(got);
    check("R10 lower entry first", {24'h0, dlvVector}, 32'h60);
    ackDlv();
    waitDlv(got);
    check("R10 higher entry next", {23'h0, got, dlvVector}, {23'h0, 1'b1, 8'h61});
    ackDlv();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule